// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Generator

This block produces several independent pulse-width-modulated outputs from a single clock. Each channel owns a 16-bit up-counter advanced through a prescaler whose divide ratio comes from a fixed, non-uniform table. A channel's waveform is shaped by two software-visible words: a timing word holding the count where the active phase starts and the count where it ends, and a period word holding the period length, the prescaler select and a 2-bit output level code for each of the two phases. A shared enable word carries one bit per channel.

Software changes a running channel without glitches. Both words are staged. Writing the timing word alone changes nothing on the output. Writing the period word arms the channel, and the staged pair is copied into the working registers at the next counter wrap. Every word can be written directly or through set, clear and toggle alias addresses. The register port is a plain write strobe with a combinational read. It is always ready and has no back-pressure: a write is taken on every edge where `wr_en` is high.

Top module: `pwm_multi`

## Requirements
- R1: The enable word is at address 0x00, channel n's timing word at 0x10+0x20·n and channel n's period word at 0x20+0x20·n. A read at one of these base addresses returns the word's current (staged) contents. Reads at alias or unmapped addresses return 0. After reset every word reads 0 and every output is low.
- R2: A write to base+0x0 replaces the word. Base+0x4 sets the 1-bits of the data, base+0x8 clears them and base+0xC toggles them. All other bits keep their value.
- R3: Bit n of the enable word enables channel n. While the bit is 0 the channel's output is low and its counter and prescaler are held at zero. After the bit is set, the channel starts at count 0 in the cycle after the write, using the staged words.
- R4: The counter runs from 0 to P-1 and then wraps to 0, where P is period-word bits 15:0. A value of 0 means 65536 counts.
- R5: Period-word bits 22:20 select the prescaler. Codes 0..7 advance the counter once every 1, 2, 4, 8, 16, 64, 256 or 1024 clocks.
- R6: The channel is in its active phase while start ≤ count < switch. Start is timing-word bits 15:0 and switch is timing-word bits 31:16. Otherwise it is in its inactive phase.
- R7: Period-word bits 17:16 give the active-phase level and bits 19:18 the inactive-phase level. Level code 3 drives the output high. Codes 0, 1 and 2 drive it low.
- R8: On an enabled channel, writing only the timing word does not change the waveform.
- R9: A period-word write arms the channel. The staged words take effect at the first wrap that follows the write, and the count restarts at 0 under the new settings. A write landing on the same clock edge as a wrap is not committed at that wrap but at the next one.
- R10: Channels run independently. Enabling or reprogramming one channel leaves the other channels' waveforms unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (combinational) |
| pwm_out | output | NCH | One waveform output per channel |

## Verification
The collision that matters is a period-word write landing on the same edge as that channel's counter wrap. The bench waits until the running count sits on its last value, then issues the write. It checks every following cycle against a model in which the old waveform continues for one more full period before the new period begins at count 0. A second case writes only the timing word to a running channel and checks that the waveform is unchanged over several periods. The other channel runs the whole time, which confirms it is not disturbed.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
  localparam int CNT_W  = 16;
  localparam int PER_W  = 23;
  localparam int DIV_W  = 10;
  localparam int LVA_LO = 16;
  localparam int LVI_LO = 18;
  localparam int SEL_LO = 20;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } wr_op_e;

  // terminal value of the prescaler for a select code (divisor - 1)
  function automatic logic [DIV_W-1:0] div_last(input logic [2:0] code);
    case (code)
      3'd0: return DIV_W'(0);
      3'd1: return DIV_W'(1);
      3'd2: return DIV_W'(3);
      3'd3: return DIV_W'(7);
      3'd4: return DIV_W'(15);
      3'd5: return DIV_W'(63);
      3'd6: return DIV_W'(255);
      default: return DIV_W'(1023);
    endcase
  endfunction

  function automatic logic [31:0] apply_op(input wr_op_e op, input logic [31:0] old_v,
                                           input logic [31:0] d);
    case (op)
      OP_SET:  return old_v | d;
      OP_CLR:  return old_v & ~d;
      OP_TOG:  return old_v ^ d;
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/pwm_addr_decode.sv
`timescale 1ns/1ps
module pwm_addr_decode
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_ctrl,
  output logic [NCH-1:0]    hit_act,
  output logic [NCH-1:0]    hit_per,
  output wr_op_e            op
);
  localparam int GW = ADDR_W - 5;

  logic [GW-1:0] grp;
  logic          upper_half;
  logic          aligned;

  assign grp        = addr[ADDR_W-1:5];
  assign upper_half = addr[4];
  assign aligned    = (addr[1:0] == 2'b00);
  assign op         = wr_op_e'(addr[3:2]);
  assign hit_ctrl   = aligned && !upper_half && (grp == '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign hit_act[g] = aligned &&  upper_half && (grp == GW'(g));
    assign hit_per[g] = aligned && !upper_half && (grp == GW'(g + 1));
  end
endmodule

// File: rtl/pwm_channel.sv
`timescale 1ns/1ps
module pwm_channel
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             per_wr,
  input  logic [31:0]      act_stage,
  input  logic [PER_W-1:0] per_stage,
  output logic             pwm,
  output logic             wrap,
  output logic             armed,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] last,
  output logic [31:0]      work_act,
  output logic [PER_W-1:0] work_per
);
  logic [DIV_W-1:0] presc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [31:0]      wact_q;
  logic [PER_W-1:0] wper_q;
  logic             tick;
  logic             in_active;
  logic [1:0]       level;

  assign last      = wper_q[CNT_W-1:0] - CNT_W'(1);
  assign tick      = (presc_q == div_last(wper_q[SEL_LO +: 3]));
  assign wrap      = en && tick && (cnt_q == last);
  assign in_active = (cnt_q >= wact_q[CNT_W-1:0]) && (cnt_q < wact_q[31:16]);
  assign level     = in_active ? wper_q[LVA_LO +: 2] : wper_q[LVI_LO +: 2];
  assign pwm       = en && (level == 2'b11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      wact_q  <= '0;
      wper_q  <= '0;
    end else if (!en) begin
      presc_q <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      wact_q  <= act_stage;
      wper_q  <= per_stage;
    end else begin
      presc_q <= tick ? '0 : presc_q + DIV_W'(1);
      if (tick) cnt_q <= wrap ? '0 : cnt_q + CNT_W'(1);
      if (wrap && armed_q) begin
        wact_q <= act_stage;
        wper_q <= per_stage;
      end
      armed_q <= per_wr || (armed_q && !wrap);
    end
  end

  assign armed    = armed_q;
  assign cnt      = cnt_q;
  assign work_act = wact_q;
  assign work_per = wper_q;
endmodule

// File: rtl/pwm_multi.sv
`timescale 1ns/1ps
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = $clog2(32 * (NCH + 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [NCH-1:0]    pwm_out
);
  logic                        w_ctrl, r_ctrl;
  logic [NCH-1:0]              w_act, w_per, r_act, r_per;
  wr_op_e                      w_op, r_op;

  logic [NCH-1:0]              ctrl_q;
  logic [NCH-1:0][31:0]        act_q;
  logic [NCH-1:0][PER_W-1:0]   per_q;
  logic [NCH-1:0]              per_wr_v;
  logic [NCH-1:0]              wrap_v;
  logic [NCH-1:0]              armed_v;
  logic [NCH-1:0][CNT_W-1:0]   cnt_v;
  logic [NCH-1:0][CNT_W-1:0]   last_v;
  logic [NCH-1:0][31:0]        wact_v;
  logic [NCH-1:0][PER_W-1:0]   wper_v;

  pwm_addr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) wdec_i (
    .addr(wr_addr), .hit_ctrl(w_ctrl), .hit_act(w_act), .hit_per(w_per), .op(w_op)
  );
  pwm_addr_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) rdec_i (
    .addr(rd_addr), .hit_ctrl(r_ctrl), .hit_act(r_act), .hit_per(r_per), .op(r_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (wr_en && w_ctrl)  ctrl_q <= NCH'(apply_op(w_op, 32'(ctrl_q), wr_data));
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act_q[g] <= '0;
        per_q[g] <= '0;
      end else if (wr_en) begin
        if (w_act[g]) act_q[g] <= apply_op(w_op, act_q[g], wr_data);
        if (w_per[g]) per_q[g] <= PER_W'(apply_op(w_op, 32'(per_q[g]), wr_data));
      end
    end

    assign per_wr_v[g] = wr_en && w_per[g];

    pwm_channel ch_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (ctrl_q[g]),
      .per_wr   (per_wr_v[g]),
      .act_stage(act_q[g]),
      .per_stage(per_q[g]),
      .pwm      (pwm_out[g]),
      .wrap     (wrap_v[g]),
      .armed    (armed_v[g]),
      .cnt      (cnt_v[g]),
      .last     (last_v[g]),
      .work_act (wact_v[g]),
      .work_per (wper_v[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (r_op == OP_WRITE) begin
      if (r_ctrl) rd_data = 32'(ctrl_q);
      for (int i = 0; i < NCH; i++) begin
        if (r_act[i]) rd_data = act_q[i];
        if (r_per[i]) rd_data = 32'(per_q[i]);
      end
    end
  end
endmodule

// File: rtl/pwm_multi_chk.sv
`timescale 1ns/1ps
module pwm_multi_chk
  import pwm_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NCH-1:0]            en,
  input logic [NCH-1:0]            pwm_out,
  input logic [NCH-1:0]            per_wr,
  input logic [NCH-1:0]            wrap,
  input logic [NCH-1:0]            armed,
  input logic [NCH-1:0][CNT_W-1:0] cnt,
  input logic [NCH-1:0][CNT_W-1:0] last,
  input logic [NCH-1:0][31:0]      wact,
  input logic [NCH-1:0][PER_W-1:0] wper
);
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    p_off_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] |-> !pwm_out[g]);
    p_off_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !en[g] |=> (cnt[g] == '0));
    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en[g] |-> (cnt[g] <= last[g]));
    p_act_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && !wrap[g]) |=> ($stable(wact[g]) && $stable(wper[g])));
    p_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && wrap[g] && armed[g] && !per_wr[g]) |=> !armed[g]);
    p_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (en[g] && per_wr[g]) |=> armed[g]);
  end
endmodule

bind pwm_multi pwm_multi_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst_n(rst_n), .en(ctrl_q), .pwm_out(pwm_out), .per_wr(per_wr_v),
  .wrap(wrap_v), .armed(armed_v), .cnt(cnt_v), .last(last_v), .wact(wact_v), .wper(wper_v)
);

// File: tb/pwm_multi_tb_top.sv
`timescale 1ns/1ps
module pwm_multi_tb_top;
  localparam int NCH = 2;
  localparam int AW  = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [31:0]   rd_data;
  logic [NCH-1:0] pwm_out;

  pwm_multi #(.NCH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // channel models
  bit on0 = 0, on1 = 0;
  int base0 = 0, base1 = 0;
  int p0, c0, s0, w0, a0, i0;
  int p1, c1, s1, w1, a1, i1;
  int q1, d1, t1s, t1w, b1, j1;
  int tw1 = 1 << 30;

  function automatic int ra_act(int n); return 16 + 32 * n; endfunction
  function automatic int ra_per(int n); return 32 + 32 * n; endfunction
  function automatic logic [31:0] pword(int p, int code, int la, int li);
    return (code << 20) | (li << 18) | (la << 16) | (p & 32'hFFFF);
  endfunction
  function automatic logic [31:0] aword(int st, int sw);
    return (sw << 16) | st;
  endfunction
  function automatic logic model(int p, int code, int st, int sw, int la, int li, int t);
    int dv;
    int c;
    int lv;
    dv = (code < 5) ? (1 << code) : (1 << (2 * code - 4));
    c  = (t / dv) % p;
    lv = ((c >= st) && (c < sw)) ? la : li;
    return lv == 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rdchk(string req, int a, logic [31:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  // check both outputs in this cycle, then advance one cycle
  task automatic step(string req1);
    int t0;
    int t1;
    t0 = cyc - base0;
    t1 = cyc - base1;
    if (on0) chk("R10", pwm_out[0], model(p0, c0, s0, w0, a0, i0, t0));
    else     chk("R3", pwm_out[0], 0);
    if (!on1)          chk("R3", pwm_out[1], 0);
    else if (t1 <= tw1) chk(req1, pwm_out[1], model(p1, c1, s1, w1, a1, i1, t1));
    else               chk(req1, pwm_out[1], model(q1, d1, t1s, t1w, b1, j1, t1 - tw1 - 1));
    @(negedge clk);
  endtask

  task automatic wr_step(int a, logic [31:0] d, string req1);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    step(req1);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and map
    chk("R1", pwm_out, 0);
    rdchk("R1", 0, 0);
    rdchk("R1", ra_act(0), 0);
    rdchk("R1", ra_per(1), 0);
    @(negedge clk);

    // R2 aliases on a timing word
    wr(ra_act(0), 32'h00F0_000F);
    rdchk("R2", ra_act(0), 32'h00F0_000F); @(negedge clk);
    wr(ra_act(0) + 4, 32'h0100_0000);
    rdchk("R2", ra_act(0), 32'h01F0_000F); @(negedge clk);
    wr(ra_act(0) + 8, 32'h0000_000F);
    rdchk("R2", ra_act(0), 32'h01F0_0000); @(negedge clk);
    wr(ra_act(0) + 12, 32'hFFFF_0000);
    rdchk("R2", ra_act(0), 32'hFE0F_0000);
    rdchk("R1", ra_act(0) + 4, 0);
    rdchk("R1", ra_act(1), 0); @(negedge clk);
    // R2 aliases on the enable word (staged levels are 0, outputs stay low)
    wr(4, 1);    rdchk("R2", 0, 1); @(negedge clk);
    wr(12, 3);   rdchk("R2", 0, 2); @(negedge clk);
    wr(8, 2);    rdchk("R2", 0, 0);
    wr(ra_per(1), pword(9, 2, 3, 2));
    rdchk("R1", ra_per(1), pword(9, 2, 3, 2)); @(negedge clk);
    chk("R7", pwm_out, 0);

    // R5/R6 prescaler sweep over every select code, fresh start each time (R3)
    for (int code = 0; code < 8; code++) begin
      int dv;
      dv = (code < 5) ? (1 << code) : (1 << (2 * code - 4));
      wr(ra_act(0), aword(1, 3));
      wr(ra_per(0), pword(5, code, 3, 2));
      wr(4, 1);
      base0 = cyc;
      for (int k = 0; k < 2 * 5 * dv; k++) begin
        chk("R5", pwm_out[0], model(5, code, 1, 3, 3, 2, cyc - base0));
        @(negedge clk);
      end
      wr(8, 1);
      chk("R3", pwm_out[0], 0);
      @(negedge clk);
    end

    // R7 level codes
    for (int v = 0; v < 3; v++) begin
      int la;
      int li;
      la = (v == 0) ? 2 : (v == 1) ? 1 : 3;
      li = (v == 0) ? 3 : (v == 1) ? 0 : 3;
      wr(ra_act(0), aword(0, 2));
      wr(ra_per(0), pword(5, 0, la, li));
      wr(4, 1);
      base0 = cyc;
      for (int k = 0; k < 12; k++) begin
        chk("R7", pwm_out[0], model(5, 0, 0, 2, la, li, cyc - base0));
        @(negedge clk);
      end
      wr(8, 1);
    end

    // R4 period field 0 means 65536 counts
    wr(ra_act(0), aword(0, 32768));
    wr(ra_per(0), pword(0, 0, 3, 2));
    wr(4, 1);
    base0 = cyc;
    for (int k = 0; k < 65540; k++) begin
      chk("R4", pwm_out[0], model(65536, 0, 0, 32768, 3, 2, cyc - base0));
      @(negedge clk);
    end
    wr(8, 1);

    // R8/R9/R10 both channels running
    p0 = 3; c0 = 1; s0 = 0; w0 = 1; a0 = 3; i0 = 2;
    p1 = 4; c1 = 0; s1 = 0; w1 = 2; a1 = 3; i1 = 2;
    wr(ra_act(0), aword(s0, w0));
    wr(ra_per(0), pword(p0, c0, a0, i0));
    wr(ra_act(1), aword(s1, w1));
    wr(ra_per(1), pword(p1, c1, a1, i1));
    wr(4, 3);
    base0 = cyc; base1 = cyc; on0 = 1; on1 = 1; tw1 = 1 << 30;
    repeat (6) step("R10");
    wr_step(ra_act(1), aword(0, 3), "R8");
    repeat (12) step("R8");
    while (((cyc - base1) % p1) != p1 - 1) step("R8");
    // period write lands on the wrap edge: commit waits one more period
    q1 = 6; d1 = 0; t1s = 0; t1w = 3; b1 = 3; j1 = 2;
    tw1 = (cyc - base1) + p1;
    wr_step(ra_per(1), pword(q1, d1, b1, j1), "R9");
    repeat (30) step("R9");
    // disable channel 1, channel 0 unaffected
    wr_step(8, 2, "R9");
    on1 = 0;
    repeat (5) step("R3");
    // re-enable: fresh period with the committed staged words
    wr_step(4, 2, "R3");
    on1 = 1; base1 = cyc; tw1 = 1 << 30;
    p1 = q1; c1 = d1; s1 = t1s; w1 = t1w; a1 = b1; i1 = j1;
    repeat (14) step("R3");

    finish_run();
  end
endmodule